// File: doc/BRIEF.md
# Physical Register Free List with Per-Branch Recovery Masks

This block keeps track of which physical registers are unused in an out-of-order core that renames registers. Its state is a bit vector with one bit per physical register, where 1 means free. Each cycle it can hand out up to two registers. Lane 0 takes the lowest-numbered free register and lane 1 takes the highest-numbered one, so the two picks never collide while two or more registers are free. When an instruction commits, it hands back its stale destination on one of two return lanes.

Speculation is tracked with a small set of branch slots. Opening a slot starts an empty allocation mask. Every register granted while the slot stays open is added to that mask. A slot is closed by resolution or by a mispredict. A mispredict ORs the slot's mask into the free vector and gives back all the registers that the wrong path took. The vector is never copied and restored. A register that was returned and then handed out again on the wrong path is therefore still recovered.

Top module: `fl_free_list`

## Requirements
- R1: After reset, registers 0 to NUM_ARCH-1 are allocated and all others are free, so `free_cnt` reads NUM_PREGS-NUM_ARCH. The first two-lane grant after reset returns NUM_ARCH on lane 0 and NUM_PREGS-1 on lane 1.
- R2: In the same cycle as the request, lane 0 offers the lowest-indexed free register and lane 1 offers the highest-indexed free register. When both lanes are granted, the two numbers differ.
- R3: `alloc_ready` is 1 exactly when no mispredict is signalled and `free_cnt` is at least the number of set bits in `alloc_req`. `alloc_gnt` equals `alloc_req` when ready and is 0 otherwise, so a shortfall grants nothing.
- R4: Registers granted in a cycle are no longer free from the next cycle. `free_cnt` drops by the number of grants.
- R5: A register on a valid return lane is free from the next cycle. `free_cnt` rises by the number of valid return lanes.
- R6: Opening a branch slot clears its mask. A grant made in the same cycle as the open is not recorded in the new mask. Grants made in later cycles, while the slot is open, are recorded.
- R7: A mispredict on a slot ORs that slot's mask into the free vector at the next edge and closes the slot. No register is granted in the mispredict cycle.
- R8: Resolving a slot closes it and clears its mask without touching the free vector. A later mispredict on that closed slot frees nothing.
- R9: A register that is returned while a branch is open and then granted again under that branch is free again after that branch mispredicts.
- R10: A grant is recorded in the mask of every open slot. A mispredict on an older slot therefore also recovers registers taken after a younger branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 2 | Allocation request, one bit per lane |
| alloc_ready | output | 1 | All requested lanes can be served this cycle |
| alloc_gnt | output | 2 | Granted lanes |
| alloc_preg0 | output | PW | Register offered to lane 0 (lowest free) |
| alloc_preg1 | output | PW | Register offered to lane 1 (highest free) |
| ret_valid | input | 2 | Stale-destination return valid, one bit per lane |
| ret_preg0 | input | PW | Register returned on lane 0 |
| ret_preg1 | input | PW | Register returned on lane 1 |
| br_open | input | 1 | Open a branch slot with an empty mask |
| br_open_tag | input | BW | Slot to open |
| br_resolve | input | 1 | Close a slot after a correct prediction |
| br_resolve_tag | input | BW | Slot to resolve |
| br_kill | input | 1 | Mispredict: recover a slot's mask |
| br_kill_tag | input | BW | Slot that mispredicted |
| free_cnt | output | CW | Number of free registers |

## Verification
`alloc_ready`, `alloc_gnt` and both offered register numbers are combinational from the current free vector and the inputs. The bench reads them one time unit after it drives the inputs on the falling edge, which is before the rising edge that consumes them. Grants, returns and mispredict recovery take effect at the next rising edge. The bench therefore updates its own model after that edge and compares `free_cnt` at the following falling edge, one cycle after the stimulus. Directed sequences for reset, shortfall, same-cycle open, resolve, nested branches and the return-then-reallocate case also compare `free_cnt` against counts worked out by hand at that same point.

// File: rtl/fl_pkg.sv
package fl_pkg;

    localparam int unsigned LANES = 2;

    typedef enum logic {
        SCAN_LOW,
        SCAN_HIGH
    } scan_dir_e;

    typedef enum logic [1:0] {
        SLOT_HOLD,
        SLOT_OPEN,
        SLOT_CLOSE
    } slot_op_e;

    function automatic logic [1:0] lanes_needed(input logic [LANES-1:0] req);
        return {1'b0, req[0]} + {1'b0, req[1]};
    endfunction

endpackage

// File: rtl/fl_pick.sv
module fl_pick
    import fl_pkg::*;
#(
    parameter int unsigned N   = 64,
    parameter scan_dir_e   DIR = SCAN_LOW,
    localparam int unsigned W  = $clog2(N)
) (
    input  logic [N-1:0] vec,
    output logic         found,
    output logic [W-1:0] idx
);
    generate
        if (DIR == SCAN_LOW) begin : g_low
            always_comb begin
                found = 1'b0;
                idx   = '0;
                for (int i = N - 1; i >= 0; i--) begin
                    if (vec[i]) begin
                        found = 1'b1;
                        idx   = W'(i);
                    end
                end
            end
        end else begin : g_high
            always_comb begin
                found = 1'b0;
                idx   = '0;
                for (int i = 0; i < N; i++) begin
                    if (vec[i]) begin
                        found = 1'b1;
                        idx   = W'(i);
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/fl_popcount.sv
module fl_popcount #(
    parameter int unsigned N  = 64,
    localparam int unsigned CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < N; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/fl_br_masks.sv
module fl_br_masks
    import fl_pkg::*;
#(
    parameter int unsigned N  = 64,
    parameter int unsigned NB = 4,
    localparam int unsigned BW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          open,
    input  logic [BW-1:0] open_tag,
    input  logic          resolve,
    input  logic [BW-1:0] resolve_tag,
    input  logic          kill,
    input  logic [BW-1:0] kill_tag,
    input  logic [N-1:0]  gnt_vec,
    output logic [N-1:0]  kill_mask
);
    logic [N-1:0]  mask_q [NB];
    logic [NB-1:0] live_q;

    generate
        for (genvar s = 0; s < NB; s++) begin : g_slot
            slot_op_e op;

            always_comb begin
                if (open && open_tag == BW'(s))
                    op = SLOT_OPEN;
                else if ((resolve && resolve_tag == BW'(s)) ||
                         (kill && kill_tag == BW'(s)))
                    op = SLOT_CLOSE;
                else
                    op = SLOT_HOLD;
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    live_q[s] <= 1'b0;
                    mask_q[s] <= '0;
                end else begin
                    unique case (op)
                        SLOT_OPEN: begin
                            live_q[s] <= 1'b1;
                            mask_q[s] <= '0;
                        end
                        SLOT_CLOSE: begin
                            live_q[s] <= 1'b0;
                            mask_q[s] <= '0;
                        end
                        default: begin
                            if (live_q[s])
                                mask_q[s] <= mask_q[s] | gnt_vec;
                        end
                    endcase
                end
            end
        end
    endgenerate

    assign kill_mask = kill ? mask_q[kill_tag] : '0;
endmodule

// File: rtl/fl_free_list.sv
module fl_free_list
    import fl_pkg::*;
#(
    parameter int unsigned NUM_PREGS = 64,
    parameter int unsigned NUM_ARCH  = 32,
    parameter int unsigned NUM_BR    = 4,
    localparam int unsigned PW = $clog2(NUM_PREGS),
    localparam int unsigned BW = (NUM_BR > 1) ? $clog2(NUM_BR) : 1,
    localparam int unsigned CW = $clog2(NUM_PREGS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    alloc_req,
    output logic          alloc_ready,
    output logic [1:0]    alloc_gnt,
    output logic [PW-1:0] alloc_preg0,
    output logic [PW-1:0] alloc_preg1,
    input  logic [1:0]    ret_valid,
    input  logic [PW-1:0] ret_preg0,
    input  logic [PW-1:0] ret_preg1,
    input  logic          br_open,
    input  logic [BW-1:0] br_open_tag,
    input  logic          br_resolve,
    input  logic [BW-1:0] br_resolve_tag,
    input  logic          br_kill,
    input  logic [BW-1:0] br_kill_tag,
    output logic [CW-1:0] free_cnt
);
    logic [NUM_PREGS-1:0] free_q;
    logic [NUM_PREGS-1:0] free_d;
    logic [NUM_PREGS-1:0] gnt_vec;
    logic [NUM_PREGS-1:0] ret_vec;
    logic [NUM_PREGS-1:0] kill_mask;
    logic                 lo_found;
    logic                 hi_found;

    fl_pick #(.N(NUM_PREGS), .DIR(SCAN_LOW)) u_pick_lo (
        .vec  (free_q),
        .found(lo_found),
        .idx  (alloc_preg0)
    );

    fl_pick #(.N(NUM_PREGS), .DIR(SCAN_HIGH)) u_pick_hi (
        .vec  (free_q),
        .found(hi_found),
        .idx  (alloc_preg1)
    );

    fl_popcount #(.N(NUM_PREGS)) u_count (
        .vec(free_q),
        .cnt(free_cnt)
    );

    // All-or-nothing grant: with two or more free, the two scans differ.
    always_comb begin
        alloc_ready = !br_kill && (free_cnt >= CW'(lanes_needed(alloc_req)));
        alloc_gnt   = alloc_ready ? alloc_req : 2'b00;
    end

    always_comb begin
        gnt_vec = '0;
        ret_vec = '0;
        if (alloc_gnt[0] && lo_found) gnt_vec[alloc_preg0] = 1'b1;
        if (alloc_gnt[1] && hi_found) gnt_vec[alloc_preg1] = 1'b1;
        if (ret_valid[0]) ret_vec[ret_preg0] = 1'b1;
        if (ret_valid[1]) ret_vec[ret_preg1] = 1'b1;
    end

    fl_br_masks #(.N(NUM_PREGS), .NB(NUM_BR)) u_masks (
        .clk        (clk),
        .rst        (rst),
        .open       (br_open),
        .open_tag   (br_open_tag),
        .resolve    (br_resolve),
        .resolve_tag(br_resolve_tag),
        .kill       (br_kill),
        .kill_tag   (br_kill_tag),
        .gnt_vec    (gnt_vec),
        .kill_mask  (kill_mask)
    );

    assign free_d = (free_q & ~gnt_vec) | ret_vec | kill_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_PREGS; i++)
                free_q[i] <= (i >= NUM_ARCH);
        end else begin
            free_q <= free_d;
        end
    end
endmodule

// File: rtl/fl_free_list_chk.sv
module fl_free_list_chk #(
    parameter int unsigned NUM_PREGS = 64,
    parameter int unsigned NUM_ARCH  = 32,
    localparam int unsigned PW = $clog2(NUM_PREGS),
    localparam int unsigned CW = $clog2(NUM_PREGS + 1)
) (
    input logic                 clk,
    input logic                 rst,
    input logic [1:0]           alloc_req,
    input logic                 alloc_ready,
    input logic [1:0]           alloc_gnt,
    input logic [PW-1:0]        alloc_preg0,
    input logic [PW-1:0]        alloc_preg1,
    input logic [1:0]           ret_valid,
    input logic [PW-1:0]        ret_preg0,
    input logic                 br_kill,
    input logic [NUM_PREGS-1:0] free_q,
    input logic [CW-1:0]        free_cnt
);
    AST_RESET_COUNT: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> free_cnt == CW'(NUM_PREGS - NUM_ARCH)); // R1

    AST_GNT0_WAS_FREE: assert property (@(posedge clk) disable iff (rst)
        alloc_gnt[0] |-> free_q[alloc_preg0]); // R2

    AST_LANES_DISTINCT: assert property (@(posedge clk) disable iff (rst)
        (&alloc_gnt) |-> alloc_preg0 != alloc_preg1); // R2

    AST_GNT_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        (alloc_gnt != 2'b00) |-> (alloc_ready && alloc_gnt == alloc_req)); // R3

    AST_COUNT_DROP: assert property (@(posedge clk) disable iff (rst)
        (ret_valid == 2'b00 && !br_kill) |=>
        free_cnt == $past(free_cnt) - CW'($countones($past(alloc_gnt)))); // R4

    AST_RET_WAS_TAKEN: assert property (@(posedge clk) disable iff (rst)
        ret_valid[0] |-> !free_q[ret_preg0]); // R5

    AST_KILL_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        br_kill |-> alloc_gnt == 2'b00); // R7
endmodule

bind fl_free_list fl_free_list_chk #(
    .NUM_PREGS(NUM_PREGS),
    .NUM_ARCH (NUM_ARCH)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .alloc_req  (alloc_req),
    .alloc_ready(alloc_ready),
    .alloc_gnt  (alloc_gnt),
    .alloc_preg0(alloc_preg0),
    .alloc_preg1(alloc_preg1),
    .ret_valid  (ret_valid),
    .ret_preg0  (ret_preg0),
    .br_kill    (br_kill),
    .free_q     (free_q),
    .free_cnt   (free_cnt)
);

// File: tb/tb_fl_free_list.sv
module tb_fl_free_list;
    localparam int NP = 16;
    localparam int NA = 8;
    localparam int NB = 4;
    localparam int PW = 4;
    localparam int BW = 2;
    localparam int CW = 5;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    alloc_req;
    logic          alloc_ready;
    logic [1:0]    alloc_gnt;
    logic [PW-1:0] alloc_preg0, alloc_preg1;
    logic [1:0]    ret_valid;
    logic [PW-1:0] ret_preg0, ret_preg1;
    logic          br_open, br_resolve, br_kill;
    logic [BW-1:0] br_open_tag, br_resolve_tag, br_kill_tag;
    logic [CW-1:0] free_cnt;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fl_free_list #(.NUM_PREGS(NP), .NUM_ARCH(NA), .NUM_BR(NB)) dut (
        .clk(clk), .rst(rst),
        .alloc_req(alloc_req), .alloc_ready(alloc_ready), .alloc_gnt(alloc_gnt),
        .alloc_preg0(alloc_preg0), .alloc_preg1(alloc_preg1),
        .ret_valid(ret_valid), .ret_preg0(ret_preg0), .ret_preg1(ret_preg1),
        .br_open(br_open), .br_open_tag(br_open_tag),
        .br_resolve(br_resolve), .br_resolve_tag(br_resolve_tag),
        .br_kill(br_kill), .br_kill_tag(br_kill_tag),
        .free_cnt(free_cnt)
    );

    bit [NP-1:0] mfree;
    bit [NP-1:0] mmask [NB];
    bit [NB-1:0] mlive;
    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int lowest(input bit [NP-1:0] v);
        for (int i = 0; i < NP; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic int highest(input bit [NP-1:0] v);
        for (int i = NP - 1; i >= 0; i--) if (v[i]) return i;
        return -1;
    endfunction

    function automatic bit in_any_mask(input int r);
        for (int s = 0; s < NB; s++) if (mlive[s] && mmask[s][r]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int pick_ret(input int start, input int excl);
        for (int i = 0; i < NP; i++) begin
            int j;
            j = (start + i) % NP;
            if (!mfree[j] && !in_any_mask(j) && j != excl) return j;
        end
        return -1;
    endfunction

    task automatic drive(input bit [1:0] req, input bit [1:0] rv, input int rp0, input int rp1,
                         input bit op, input int ot, input bit rs, input int rt,
                         input bit kl, input int kt);
        alloc_req = req;  ret_valid = rv;
        ret_preg0 = PW'(rp0); ret_preg1 = PW'(rp1);
        br_open = op; br_open_tag = BW'(ot);
        br_resolve = rs; br_resolve_tag = BW'(rt);
        br_kill = kl; br_kill_tag = BW'(kt);
    endtask

    // One cycle: inputs already driven after a falling edge.
    task automatic cyc(input string cnt_req);
        int cnt, need;
        bit exp_rdy;
        bit [1:0] exp_gnt;
        bit [NP-1:0] gv, rv, nfree;
        #1;
        cnt  = $countones(mfree);
        need = int'(alloc_req[0]) + int'(alloc_req[1]);
        exp_rdy = !br_kill && cnt >= need;
        exp_gnt = exp_rdy ? alloc_req : 2'b00;
        chk(alloc_ready == exp_rdy, "R3 ready", int'(alloc_ready), int'(exp_rdy));
        chk(alloc_gnt == exp_gnt, "R3 grant", int'(alloc_gnt), int'(exp_gnt));
        gv = '0;
        if (exp_gnt[0]) begin
            chk(int'(alloc_preg0) == lowest(mfree), "R2 lane0", int'(alloc_preg0), lowest(mfree));
            gv[lowest(mfree)] = 1'b1;
        end
        if (exp_gnt[1]) begin
            chk(int'(alloc_preg1) == highest(mfree), "R2 lane1", int'(alloc_preg1), highest(mfree));
            gv[highest(mfree)] = 1'b1;
        end
        rv = '0;
        if (ret_valid[0]) rv[ret_preg0] = 1'b1;
        if (ret_valid[1]) rv[ret_preg1] = 1'b1;
        nfree = (mfree & ~gv) | rv;
        if (br_kill && mlive[br_kill_tag]) nfree = nfree | mmask[br_kill_tag];
        @(posedge clk);
        mfree = nfree;
        for (int s = 0; s < NB; s++) begin
            if (br_open && int'(br_open_tag) == s) begin
                mlive[s] = 1'b1; mmask[s] = '0;
            end else if ((br_resolve && int'(br_resolve_tag) == s) ||
                         (br_kill && int'(br_kill_tag) == s)) begin
                mlive[s] = 1'b0; mmask[s] = '0;
            end else if (mlive[s]) begin
                mmask[s] = mmask[s] | gv;
            end
        end
        @(negedge clk);
        chk(int'(free_cnt) == $countones(mfree), cnt_req, int'(free_cnt), $countones(mfree));
    endtask

    task automatic idle();
        drive(2'b00, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NP; i++) mfree[i] = (i >= NA);
        mlive = '0;
        for (int s = 0; s < NB; s++) mmask[s] = '0;
        #1;
        chk(int'(free_cnt) == NP - NA, "R1 reset count", int'(free_cnt), NP - NA);

        // R1 first picks
        drive(2'b11, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0);
        #1;
        chk(int'(alloc_preg0) == NA, "R1 first lane0", int'(alloc_preg0), NA);
        chk(int'(alloc_preg1) == NP - 1, "R1 first lane1", int'(alloc_preg1), NP - 1);
        cyc("R4");
        chk(int'(free_cnt) == 6, "R4 after two grants", int'(free_cnt), 6);
        drive(2'b11, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0); cyc("R4");
        drive(2'b11, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0); cyc("R4");
        drive(2'b11, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0); cyc("R4");
        chk(int'(free_cnt) == 0, "R4 drained", int'(free_cnt), 0);
        // R3 shortfall grants nothing
        drive(2'b01, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0);
        #1;
        chk(alloc_ready == 1'b0, "R3 empty ready", int'(alloc_ready), 0);
        cyc("R3");
        drive(2'b11, 2'b01, 8, 0, 0, 0, 0, 0, 0, 0); cyc("R5");
        chk(int'(free_cnt) == 1, "R5 one returned", int'(free_cnt), 1);
        drive(2'b11, 2'b10, 0, 15, 0, 0, 0, 0, 0, 0);
        #1;
        chk(alloc_gnt == 2'b00, "R3 one free two asked", int'(alloc_gnt), 0);
        cyc("R5");
        chk(int'(free_cnt) == 2, "R5 two returned", int'(free_cnt), 2);

        // R9 return-then-reallocate under a branch
        drive(2'b01, 2'b00, 0, 0, 1, 0, 0, 0, 0, 0); cyc("R6");      // takes 8, open slot 0
        drive(2'b00, 2'b01, 8, 0, 0, 0, 0, 0, 0, 0); cyc("R5");      // 8 returned
        drive(2'b01, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0); cyc("R4");      // 8 taken again
        drive(2'b10, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0); cyc("R4");      // 15 taken
        chk(int'(free_cnt) == 0, "R9 before kill", int'(free_cnt), 0);
        drive(2'b11, 2'b00, 0, 0, 0, 0, 0, 0, 1, 0);
        #1;
        chk(alloc_gnt == 2'b00, "R7 no grant on kill", int'(alloc_gnt), 0);
        cyc("R7");
        chk(int'(free_cnt) == 2, "R9 both recovered", int'(free_cnt), 2);

        // R6 grant in the open cycle is not recorded
        drive(2'b01, 2'b00, 0, 0, 1, 1, 0, 0, 0, 0); cyc("R6");
        drive(2'b00, 2'b00, 0, 0, 0, 0, 0, 0, 1, 1); cyc("R6");
        chk(int'(free_cnt) == 1, "R6 open-cycle grant kept", int'(free_cnt), 1);
        drive(2'b00, 2'b01, 8, 0, 0, 0, 0, 0, 0, 0); cyc("R5");

        // R8 resolve leaves free vector alone, closed slot frees nothing
        drive(2'b00, 2'b00, 0, 0, 1, 2, 0, 0, 0, 0); cyc("R8");
        drive(2'b11, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0); cyc("R8");
        drive(2'b00, 2'b00, 0, 0, 0, 0, 1, 2, 0, 0); cyc("R8");
        chk(int'(free_cnt) == 0, "R8 resolve unchanged", int'(free_cnt), 0);
        drive(2'b00, 2'b00, 0, 0, 0, 0, 0, 0, 1, 2); cyc("R8");
        chk(int'(free_cnt) == 0, "R8 closed slot kill", int'(free_cnt), 0);
        drive(2'b00, 2'b11, 8, 15, 0, 0, 0, 0, 0, 0); cyc("R5");

        // R10 nested branches
        drive(2'b00, 2'b00, 0, 0, 1, 0, 0, 0, 0, 0); cyc("R10");
        drive(2'b01, 2'b00, 0, 0, 1, 1, 0, 0, 0, 0); cyc("R10");     // 8 into slot 0 only
        drive(2'b10, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0); cyc("R10");     // 15 into slots 0 and 1
        drive(2'b00, 2'b00, 0, 0, 0, 0, 0, 0, 1, 1); cyc("R10");
        chk(int'(free_cnt) == 1, "R10 younger kill", int'(free_cnt), 1);
        drive(2'b00, 2'b00, 0, 0, 0, 0, 0, 0, 1, 0); cyc("R10");
        chk(int'(free_cnt) == 2, "R10 older kill", int'(free_cnt), 2);

        // Sweep: mixed traffic with one branch in flight at a time
        for (int n = 0; n < 4000; n++) begin
            bit [1:0] req, rv;
            int r0, r1, live_tag;
            bit op, rs, kl;
            string tag;
            req = 2'($urandom_range(0, 3));
            rv = '0; r0 = 0; r1 = 0;
            r0 = pick_ret($urandom_range(0, NP - 1), -1);
            if (r0 >= 0 && $urandom_range(0, 1) == 1) rv[0] = 1'b1; else r0 = 0;
            r1 = pick_ret($urandom_range(0, NP - 1), rv[0] ? r0 : -1);
            if (r1 >= 0 && $urandom_range(0, 1) == 1) rv[1] = 1'b1; else r1 = 0;
            live_tag = -1;
            for (int s = 0; s < NB; s++) if (mlive[s]) live_tag = s;
            op = 0; rs = 0; kl = 0;
            if (live_tag < 0) begin
                op = ($urandom_range(0, 4) == 0);
                live_tag = $urandom_range(0, NB - 1);
            end else begin
                case ($urandom_range(0, 9))
                    0: rs = 1'b1;
                    1: kl = 1'b1;
                    default: ;
                endcase
            end
            drive(req, rv, r0, r1, op, live_tag, rs, live_tag, kl, live_tag);
            tag = kl ? "R7" : (rv != 2'b00) ? "R5" : op ? "R6" : "R4";
            cyc(tag);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule